// File: doc/BRIEF.md
# Programmable Multi-Source Interrupt Aggregator

This block gathers a set of asynchronous interrupt request lines, organised as up to four groups of eight, and folds them into one interrupt request for the CPU. Each source line has four control bits at the same bit position in four byte-wide registers:

- a mask bit,
- a polarity bit,
- a trigger-mode bit,
- a pending bit.

Software sets up polarity and trigger mode, enables the sources it wants through the mask, and acknowledges a serviced source by writing a one to its pending bit.

Every source first passes through a synchroniser. A detector then compares the synchronised level with the value it had one cycle earlier. A source in level mode raises its pending bit in every cycle that it is active. A source in edge mode raises it only on the transition into its active level. Pending bits are sticky whatever the mask holds. The CPU request is the OR over all sources of pending AND mask. A smaller configuration leaves out the top group entirely.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: `reg_addr[3:2]` selects the register kind and `reg_addr[1:0]` selects the group. The kinds are 0 mask, 1 polarity, 2 trigger mode and 3 pending. Bit b of group g belongs to `src_in[8*g+b]`. When `reg_wr` is high at a rising edge, a mask, polarity or mode register takes `reg_wdata`. `reg_rdata` shows the addressed register combinationally.
- R3: A polarity bit of 0 makes a high input active. A polarity bit of 1 makes a low input active.
- R4: With a mode bit of 0 (level), an input that becomes active before a rising edge is reported in its pending bit after the third rising edge. The bit is set again in every cycle the input stays active.
- R5: With a mode bit of 1 (edge), the pending bit is set once per transition into the active level. Holding the input active after the bit is cleared does not set it again.
- R6: Writing a 1 to a pending bit clears it, and writing a 0 leaves it unchanged. When a clear and a detection fall in the same cycle, the bit stays set.
- R7: A pending bit is set and held regardless of its mask bit.
- R8: `irq` is high exactly when some source has both its pending and mask bits set. It follows register updates in the same cycle.
- R9: With NUM_GROUPS below 4, addresses of absent groups read zero, writes to them have no effect, and they never raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_GROUPS*GROUP_W | Asynchronous interrupt source lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register kind (bits 3:2) and group (bits 1:0) |
| reg_wdata | input | GROUP_W | Write data |
| reg_rdata | output | GROUP_W | Read data of the addressed register |
| irq | output | 1 | Combined interrupt request to the CPU |

## Verification
The properties take for granted that a register changes only through a write or a detection in the previous cycle. The one-shot property for edge mode also takes for granted that the synchronised level and the mode bit hold steady for the cycle after a detection.

Random stimulus keeps within these assumptions:
- it flips only a few source bits per cycle,
- it issues at most one register write per cycle,
- it spreads its addresses over all sixteen locations, including the group that the three-group instance lacks.

Directed sequences add the latency count, a clear racing a still-active level source, an edge source held high after its acknowledgement, and the mask toggled over a pending bit.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int KIND_W     = 2;
   localparam int GRP_SEL_W  = 2;
   localparam int REG_ADDR_W = KIND_W + GRP_SEL_W;
   localparam int MAX_GROUPS = 1 << GRP_SEL_W;

   typedef enum logic [KIND_W-1:0] {
      REG_MASK = 2'd0,
      REG_POL  = 2'd1,
      REG_MODE = 2'd2,
      REG_PEND = 2'd3
   } irqc_kind_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      end else begin
         stg_q[0] <= d;
         for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      end
   end

   assign q = stg_q[STAGES-1];
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] pol,
   input  logic [W-1:0] trig_edge,
   output logic [W-1:0] set
);
   logic [W-1:0] prev_q;
   logic [W-1:0] act_now;
   logic [W-1:0] act_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   // polarity 1 inverts the line so that a low level counts as active
   assign act_now  = lvl ^ pol;
   assign act_prev = prev_q ^ pol;
   assign set      = act_now & ~(trig_edge & act_prev);
endmodule

// File: rtl/irqc_group.sv
module irqc_group #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   input  logic         wr_mask,
   input  logic         wr_pol,
   input  logic         wr_mode,
   input  logic [W-1:0] clr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] mask_q,
   output logic [W-1:0] pol_q,
   output logic [W-1:0] mode_q,
   output logic [W-1:0] pend_q,
   output logic [W-1:0] set
);
   irqc_detect #(.W(W)) u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (lvl),
      .pol      (pol_q),
      .trig_edge(mode_q),
      .set      (set)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         pol_q  <= '0;
         mode_q <= '0;
         pend_q <= '0;
      end else begin
         if (wr_mask) mask_q <= wdata;
         if (wr_pol)  pol_q  <= wdata;
         if (wr_mode) mode_q <= wdata;
         // a new detection takes priority over a clear in the same cycle
         pend_q <= (pend_q & ~clr) | set;
      end
   end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irqc_pkg::*;
#(
   parameter int NUM_GROUPS  = 4,
   parameter int GROUP_W     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_GROUPS*GROUP_W-1:0] src_in,
   input  logic                          reg_wr,
   input  logic [REG_ADDR_W-1:0]         reg_addr,
   input  logic [GROUP_W-1:0]            reg_wdata,
   output logic [GROUP_W-1:0]            reg_rdata,
   output logic                          irq
);
   localparam int NUM_SRC = NUM_GROUPS * GROUP_W;

   if (NUM_GROUPS < 1 || NUM_GROUPS > MAX_GROUPS) begin : g_bad_groups
      $error("irq_aggregator: NUM_GROUPS must be 1..%0d", MAX_GROUPS);
   end
   if (GROUP_W < 1) begin : g_bad_width
      $error("irq_aggregator: GROUP_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("irq_aggregator: SYNC_STAGES must be at least 2");
   end

   irqc_kind_e           reg_kind;
   logic [GRP_SEL_W-1:0] reg_grp;
   logic [NUM_SRC-1:0]   src_sync;
   logic [NUM_SRC-1:0]   set_vec;
   logic [NUM_SRC-1:0]   clr_vec;
   logic [NUM_SRC-1:0]   mask_vec;
   logic [NUM_SRC-1:0]   pol_vec;
   logic [NUM_SRC-1:0]   mode_vec;
   logic [NUM_SRC-1:0]   pend_vec;

   assign reg_kind = irqc_kind_e'(reg_addr[REG_ADDR_W-1:GRP_SEL_W]);
   assign reg_grp  = reg_addr[GRP_SEL_W-1:0];

   irqc_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (src_in),
      .q    (src_sync)
   );

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      logic grp_hit;
      assign grp_hit = reg_wr && (reg_grp == GRP_SEL_W'(g));
      assign clr_vec[g*GROUP_W +: GROUP_W] =
         (grp_hit && reg_kind == REG_PEND) ? reg_wdata : '0;

      irqc_group #(.W(GROUP_W)) u_grp (
         .clk    (clk),
         .rst_n  (rst_n),
         .lvl    (src_sync[g*GROUP_W +: GROUP_W]),
         .wr_mask(grp_hit && reg_kind == REG_MASK),
         .wr_pol (grp_hit && reg_kind == REG_POL),
         .wr_mode(grp_hit && reg_kind == REG_MODE),
         .clr    (clr_vec[g*GROUP_W +: GROUP_W]),
         .wdata  (reg_wdata),
         .mask_q (mask_vec[g*GROUP_W +: GROUP_W]),
         .pol_q  (pol_vec[g*GROUP_W +: GROUP_W]),
         .mode_q (mode_vec[g*GROUP_W +: GROUP_W]),
         .pend_q (pend_vec[g*GROUP_W +: GROUP_W]),
         .set    (set_vec[g*GROUP_W +: GROUP_W])
      );
   end

   always_comb begin
      reg_rdata = '0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (reg_grp == GRP_SEL_W'(g)) begin
            case (reg_kind)
               REG_MASK: reg_rdata = mask_vec[g*GROUP_W +: GROUP_W];
               REG_POL:  reg_rdata = pol_vec[g*GROUP_W +: GROUP_W];
               REG_MODE: reg_rdata = mode_vec[g*GROUP_W +: GROUP_W];
               default:  reg_rdata = pend_vec[g*GROUP_W +: GROUP_W];
            endcase
         end
      end
   end

   assign irq = |(pend_vec & mask_vec);
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
   import irqc_pkg::*;
#(
   parameter int NUM_GROUPS = 4,
   parameter int GROUP_W    = 8
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          reg_wr,
   input logic [REG_ADDR_W-1:0]         reg_addr,
   input logic [GROUP_W-1:0]            reg_wdata,
   input logic [GROUP_W-1:0]            reg_rdata,
   input logic                          irq,
   input logic [NUM_GROUPS*GROUP_W-1:0] src_sync,
   input logic [NUM_GROUPS*GROUP_W-1:0] set_vec,
   input logic [NUM_GROUPS*GROUP_W-1:0] clr_vec,
   input logic [NUM_GROUPS*GROUP_W-1:0] mode_vec,
   input logic [NUM_GROUPS*GROUP_W-1:0] pend_vec
);
   localparam int NUM_SRC = NUM_GROUPS * GROUP_W;

   // R2: a configuration write is visible on the next read of the same address
   assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr[REG_ADDR_W-1:GRP_SEL_W] != 2'd3
              && int'(reg_addr[GRP_SEL_W-1:0]) < NUM_GROUPS)
      |=> (reg_addr != $past(reg_addr)) || (reg_rdata == $past(reg_wdata)));

   // R8: the request can only rise after a write or a detection
   assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(reg_wr) || $past(|set_vec)));

   // R9: absent groups read as zero
   assert_absent_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(reg_addr[GRP_SEL_W-1:0]) >= NUM_GROUPS) |-> (reg_rdata == '0));

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      // R6: a pending bit holds until a clear
      assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_vec[i] && !clr_vec[i]) |=> pend_vec[i]);
      // R6: a clear without a racing detection empties the bit
      assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_vec[i] && !set_vec[i]) |=> !pend_vec[i]);
      // R4 / R7: every detection lands in the pending bit
      assert_detect_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
         set_vec[i] |=> pend_vec[i]);
      // R5: an edge source fires once while its level and mode stay put
      assert_edge_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (set_vec[i] && mode_vec[i])
         |=> (!set_vec[i] || !$stable(src_sync[i]) || !$stable(mode_vec[i])));
   end
endmodule

bind irq_aggregator irq_aggregator_chk #(
   .NUM_GROUPS(NUM_GROUPS),
   .GROUP_W   (GROUP_W)
) u_chk (.*);

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_in = '0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata, rdata_s;
   logic        irq, irq_s;

   int vectors = 0;
   int fails = 0;
   bit done = 0;

   // bench model state
   logic [31:0] m_mask = '0, m_pol = '0, m_mode = '0, m_pend = '0;
   logic [31:0] m_s1 = '0, m_s2 = '0, m_prev = '0;
   logic [31:0] cur_src = '0;

   always #10 clk = ~clk;  // 50 MHz

   irq_aggregator uut (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

   irq_aggregator #(.NUM_GROUPS(3)) uut_small (
      .clk(clk), .rst_n(rst_n), .src_in(src_in[23:0]), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_s), .irq(irq_s));

   function automatic logic [7:0] model_read(input logic [3:0] a);
      logic [31:0] r;
      case (a[3:2])
         2'd0:    r = m_mask;
         2'd1:    r = m_pol;
         2'd2:    r = m_mode;
         default: r = m_pend;
      endcase
      return 8'(r >> (8 * int'(a[1:0])));
   endfunction

   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check1(input string tag, input logic act, input logic exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   // apply one cycle of stimulus, advance the model, compare at the next falling edge
   task automatic step(input logic [31:0] src, input logic wr, input logic [3:0] a,
                       input logic [7:0] wd, input string tag);
      logic [31:0] act, pact, set, clr;
      int g;
      src_in = src; reg_wr = wr; reg_addr = a; reg_wdata = wd;
      cur_src = src;
      g = int'(a[1:0]);
      act  = m_s2 ^ m_pol;
      pact = m_prev ^ m_pol;
      set  = act & ~(m_mode & pact);
      clr  = (wr && a[3:2] == 2'd3) ? (32'(wd) << (8 * g)) : '0;
      if (wr) begin
         case (a[3:2])
            2'd0: m_mask[8*g +: 8] = wd;
            2'd1: m_pol[8*g +: 8]  = wd;
            2'd2: m_mode[8*g +: 8] = wd;
            default: ;
         endcase
      end
      m_pend = (m_pend & ~clr) | set;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = src;
      @(negedge clk);
      check8({tag, " rdata"}, reg_rdata, model_read(a));
      check1({tag, " irq"}, irq, |(m_pend & m_mask));
      check8({tag, " small rdata"}, rdata_s, (a[1:0] == 2'd3) ? 8'h00 : model_read(a));
      check1({tag, " small irq"}, irq_s, |(m_pend[23:0] & m_mask[23:0]));
   endtask

   task automatic idle(input int n, input logic [3:0] a, input string tag);
      for (int k = 0; k < n; k++) step(cur_src, 1'b0, a, 8'h00, tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state on every address
      for (int a = 0; a < 16; a++) begin
         step('0, 1'b0, 4'(a), 8'h00, "R1");
         check8("R1 reset value", reg_rdata, 8'h00);
         check1("R1 reset irq", irq, 1'b0);
      end

      // R2: configuration registers read back
      step('0, 1'b1, 4'h0, 8'hA5, "R2");
      step('0, 1'b1, 4'h7, 8'h3C, "R2");
      step('0, 1'b1, 4'hA, 8'h0F, "R2");
      step('0, 1'b0, 4'h0, 8'h00, "R2"); check8("R2 mask g0", reg_rdata, 8'hA5);
      step('0, 1'b0, 4'h7, 8'h00, "R2"); check8("R2 pol g3", reg_rdata, 8'h3C);
      step('0, 1'b0, 4'hA, 8'h00, "R2"); check8("R2 mode g2", reg_rdata, 8'h0F);
      // R3: active-low sources with a low input have become pending
      step('0, 1'b0, 4'hF, 8'h00, "R3"); check8("R3 low-active pending", reg_rdata, 8'h3C);
      step('0, 1'b1, 4'h0, 8'h00, "R2");
      step('0, 1'b1, 4'h7, 8'h00, "R2");
      step('0, 1'b1, 4'hA, 8'h00, "R2");
      idle(3, 4'hF, "R3");
      for (int g = 0; g < 4; g++) step('0, 1'b1, 4'(12 + g), 8'hFF, "R6");
      for (int g = 0; g < 4; g++) begin
         step('0, 1'b0, 4'(12 + g), 8'h00, "R6");
         check8("R6 cleared", reg_rdata, 8'h00);
      end

      // R4: level latency, three edges
      step('0, 1'b1, 4'h0, 8'hFF, "R4");
      step(32'h1, 1'b0, 4'hC, 8'h00, "R4"); check8("R4 edge1", reg_rdata, 8'h00);
      idle(1, 4'hC, "R4");                   check8("R4 edge2", reg_rdata, 8'h00);
      idle(1, 4'hC, "R4");                   check8("R4 edge3", reg_rdata, 8'h01);
      check1("R8 irq with mask", irq, 1'b1);
      // R3: bit1 set active-low
      step(32'h1, 1'b1, 4'h4, 8'h02, "R3");
      idle(1, 4'hC, "R3");                   check8("R3 active low", reg_rdata, 8'h03);
      // R6: clear racing a still-active level source, and zero write
      step(32'h1, 1'b1, 4'hC, 8'h01, "R6");  check8("R6 set wins", reg_rdata, 8'h03);
      step(32'h1, 1'b1, 4'hC, 8'h00, "R6");  check8("R6 zero write", reg_rdata, 8'h03);
      step('0, 1'b1, 4'h4, 8'h00, "R6");
      idle(3, 4'hC, "R6");
      step('0, 1'b1, 4'hC, 8'h03, "R6");
      idle(1, 4'hC, "R6");                   check8("R6 clear", reg_rdata, 8'h00);
      check1("R8 irq low", irq, 1'b0);

      // R5: edge mode fires once
      step('0, 1'b1, 4'h8, 8'h04, "R5");
      step(32'h4, 1'b0, 4'hC, 8'h00, "R5");
      idle(2, 4'hC, "R5");                   check8("R5 edge seen", reg_rdata, 8'h04);
      step(32'h4, 1'b1, 4'hC, 8'h04, "R5");
      for (int k = 0; k < 4; k++) begin
         idle(1, 4'hC, "R5");                check8("R5 held high no retrigger", reg_rdata, 8'h00);
      end
      step('0, 1'b0, 4'hC, 8'h00, "R5");
      idle(2, 4'hC, "R5");
      step(32'h4, 1'b0, 4'hC, 8'h00, "R5");
      idle(2, 4'hC, "R5");                   check8("R5 second edge", reg_rdata, 8'h04);

      // R7 / R8: mask gates only the request
      step(32'h4, 1'b1, 4'h0, 8'h00, "R7");  check1("R7 masked irq", irq, 1'b0);
      idle(1, 4'hC, "R7");                   check8("R7 pending kept", reg_rdata, 8'h04);
      step(32'h4, 1'b1, 4'h0, 8'h04, "R8");  check1("R8 irq on mask write", irq, 1'b1);

      // R8 / R9: source in group 3
      step('0, 1'b1, 4'hC, 8'hFF, "R8");
      step('0, 1'b1, 4'h8, 8'h00, "R8");
      step(32'h4000_0000, 1'b1, 4'h3, 8'h40, "R9");
      check8("R9 small absent write", rdata_s, 8'h00);
      idle(2, 4'hF, "R8");
      check8("R8 group3 pending", reg_rdata, 8'h40);
      check1("R8 group3 irq", irq, 1'b1);
      check1("R9 small irq", irq_s, 1'b0);
      check8("R9 small absent read", rdata_s, 8'h00);

      // random phase
      void'($urandom(32'd20240611));
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] s;
         logic w;
         s = cur_src ^ ($urandom & $urandom & $urandom);
         w = ($urandom % 4) == 0;
         step(s, w, 4'($urandom), 8'($urandom), "random");
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule